// File: doc/BRIEF.md
# GPIO Port with Per-Pin Function Mux

This block is a general-purpose I/O port of sixteen pins driven from a simple memory-mapped register bus. Each pin is either owned by software as a plain GPIO or handed to a peripheral, which then drives the pad directly. For peripheral-owned pins, a packed 2-bit code per pin picks one of four peripheral functions. That code goes out on a function-select bus that a routing layer outside this block decodes.

Software changes single pins without a read-modify-write sequence. Both the output-data register and the direction register have write-one-to-set and write-one-to-clear aliases. An input-enable register gates each input buffer. Pad inputs pass through a synchroniser. An enabled pin reads back its synchronised pad level. A disabled pin reads back its output-data bit and presents 0 to the pin-interrupt block downstream.

The register bus is a plain control interface: a write happens on any clock edge where `reg_wr` is high, and `reg_rdata` always shows the register selected by `reg_addr` in the same cycle. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `gpio_port_mux`

## Requirements
- R1: While `rst_n` is low, the function-enable, mux, data, direction and input-enable registers all reset to 0. After reset every pin is a GPIO input with its buffer off: `pad_oe`, `func_sel`, `func_en` and `pin_irq_in` are 0, and every register read returns 0.
- R2: Writing to address 3 (data set alias) sets each data bit whose write-data bit is 1 and leaves the other data bits unchanged.
- R3: Writing to address 4 (data clear alias) clears each data bit whose write-data bit is 1 and leaves the other data bits unchanged.
- R4: Writing to address 6 (direction set alias) sets direction bits, and writing to address 7 (direction clear alias) clears them, each only where the write-data bit is 1. Reads at addresses 5, 6 and 7 return the direction register.
- R5: A write to address 0 (function enable), 1 (mux, all 32 bits), 2 (data), 5 (direction) or 8 (input enable) loads the whole register. For 16-bit registers, write-data bits 31:16 are dropped and read back as 0.
- R6: For a pin whose function-enable bit is 0, `pad_oe` equals its direction bit (1 = output) and `pad_out` equals its data bit.
- R7: For a pin whose function-enable bit is 1, `pad_out` and `pad_oe` follow `periph_out` and `periph_oe` for that pin. `func_en` mirrors the function-enable register.
- R8: `func_sel` equals the mux register. The code for pin i is at bits [2i+1:2i].
- R9: Reads at addresses 2, 3 and 4 return the pin values. An input-enabled pin returns `pad_in` after a two-flop synchroniser, so a change becomes readable after the second rising edge. A pin that is not input-enabled returns its data bit.
- R10: `pin_irq_in` equals the synchronised pad input ANDed with the input-enable register. A disabled buffer forces its bit to 0.
- R11: Addresses 9 to 15 are unmapped. Writes there change no register, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| periph_out | input | 16 | Peripheral output values for owned pins |
| periph_oe | input | 16 | Peripheral output enables for owned pins |
| func_en | output | 16 | Per-pin peripheral ownership |
| func_sel | output | 32 | Packed 2-bit function code per pin |
| pin_irq_in | output | 16 | Gated synchronised inputs for the pin-interrupt block |

## Verification
A wrong bit in the data or direction register shows up at the pads on the edge after the offending write, but only while that pin is GPIO-owned. For that reason the stimulus keeps toggling ownership and reads every address back after each operation. An alias that touches too many or too few bits leaves a neighbouring pin wrong, and that pin stays wrong until the next full write. A synchroniser with the wrong depth moves the read-back and interrupt-facing values by a whole cycle, and a directed check samples exactly the first and second edges after a pad change to catch it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [3:0] {
    ADDR_FEN     = 4'd0,
    ADDR_MUX     = 4'd1,
    ADDR_DATA    = 4'd2,
    ADDR_DATA_S  = 4'd3,
    ADDR_DATA_C  = 4'd4,
    ADDR_DIR     = 4'd5,
    ADDR_DIR_S   = 4'd6,
    ADDR_DIR_C   = 4'd7,
    ADDR_INEN    = 4'd8
  } gpio_addr_e;
  localparam int unsigned ADDR_W = 4;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*PINS-1:0]   wdata,
  input  logic [PINS-1:0]     pin_val,
  output logic [2*PINS-1:0]   rdata,
  output logic [PINS-1:0]     fen_q,
  output logic [2*PINS-1:0]   mux_q,
  output logic [PINS-1:0]     data_q,
  output logic [PINS-1:0]     dir_q,
  output logic [PINS-1:0]     inen_q
);
  localparam int unsigned BW = 2*PINS;
  logic [PINS-1:0] wlo;
  assign wlo = wdata[PINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q  <= '0;
      mux_q  <= '0;
      data_q <= '0;
      dir_q  <= '0;
      inen_q <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_FEN:    fen_q  <= wlo;
        ADDR_MUX:    mux_q  <= wdata;
        ADDR_DATA:   data_q <= wlo;
        ADDR_DATA_S: data_q <= data_q | wlo;
        ADDR_DATA_C: data_q <= data_q & ~wlo;
        ADDR_DIR:    dir_q  <= wlo;
        ADDR_DIR_S:  dir_q  <= dir_q | wlo;
        ADDR_DIR_C:  dir_q  <= dir_q & ~wlo;
        ADDR_INEN:   inen_q <= wlo;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_FEN:                          rdata = BW'(fen_q);
      ADDR_MUX:                          rdata = mux_q;
      ADDR_DATA, ADDR_DATA_S, ADDR_DATA_C: rdata = BW'(pin_val);
      ADDR_DIR, ADDR_DIR_S, ADDR_DIR_C:  rdata = BW'(dir_q);
      ADDR_INEN:                         rdata = BW'(inen_q);
      default:                           rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned PINS = 16
) (
  input  logic [PINS-1:0] fen,
  input  logic [PINS-1:0] data,
  input  logic [PINS-1:0] dir,
  input  logic [PINS-1:0] inen,
  input  logic [PINS-1:0] sync_in,
  input  logic [PINS-1:0] periph_out,
  input  logic [PINS-1:0] periph_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pin_val,
  output logic [PINS-1:0] irq_out
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      pad_out[i] = fen[i] ? periph_out[i] : data[i];
      pad_oe[i]  = fen[i] ? periph_oe[i]  : dir[i];
      pin_val[i] = inen[i] ? sync_in[i] : data[i];
      irq_out[i] = inen[i] & sync_in[i];
    end
  end
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [2*PINS-1:0]   reg_wdata,
  output logic [2*PINS-1:0]   reg_rdata,
  input  logic [PINS-1:0]     pad_in,
  output logic [PINS-1:0]     pad_out,
  output logic [PINS-1:0]     pad_oe,
  input  logic [PINS-1:0]     periph_out,
  input  logic [PINS-1:0]     periph_oe,
  output logic [PINS-1:0]     func_en,
  output logic [2*PINS-1:0]   func_sel,
  output logic [PINS-1:0]     pin_irq_in
);
  logic [PINS-1:0]   fen_q, data_q, dir_q, inen_q, sync_q, pin_val;
  logic [2*PINS-1:0] mux_q;

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(sync_q)
  );

  gpio_regfile #(.PINS(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .pin_val(pin_val), .rdata(reg_rdata),
    .fen_q(fen_q), .mux_q(mux_q), .data_q(data_q), .dir_q(dir_q),
    .inen_q(inen_q)
  );

  gpio_pad_ctrl #(.PINS(PINS)) u_pads (
    .fen(fen_q), .data(data_q), .dir(dir_q), .inen(inen_q),
    .sync_in(sync_q), .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pin_val(pin_val),
    .irq_out(pin_irq_in)
  );

  assign func_en  = fen_q;
  assign func_sel = mux_q;
endmodule

// File: rtl/gpio_port_mux_chk.sv
module gpio_port_mux_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [2*PINS-1:0]   reg_wdata,
  input logic [PINS-1:0]     pad_out,
  input logic [PINS-1:0]     pad_oe,
  input logic [PINS-1:0]     periph_out,
  input logic [PINS-1:0]     periph_oe,
  input logic [PINS-1:0]     func_en,
  input logic [2*PINS-1:0]   func_sel,
  input logic [PINS-1:0]     pin_irq_in,
  input logic [PINS-1:0]     data_q,
  input logic [PINS-1:0]     dir_q,
  input logic [PINS-1:0]     inen_q
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (func_sel == '0 && func_en == '0 && data_q == '0 && dir_q == '0));

  a_r2_data_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_DATA_S) |=>
      ((data_q & $past(reg_wdata[PINS-1:0])) == $past(reg_wdata[PINS-1:0]) &&
       (data_q & ~$past(reg_wdata[PINS-1:0])) == ($past(data_q) & ~$past(reg_wdata[PINS-1:0]))));

  a_r3_data_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_DATA_C) |=>
      ((data_q & $past(reg_wdata[PINS-1:0])) == '0 &&
       (data_q & ~$past(reg_wdata[PINS-1:0])) == ($past(data_q) & ~$past(reg_wdata[PINS-1:0]))));

  a_r4_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_DIR_S) |=> (dir_q == ($past(dir_q) | $past(reg_wdata[PINS-1:0]))));

  a_r4_dir_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_DIR_C) |=> (dir_q == ($past(dir_q) & ~$past(reg_wdata[PINS-1:0]))));

  a_r6_gpio_pads: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ dir_q) | (pad_out ^ data_q)) & ~func_en) == '0);

  a_r7_periph_pads: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ periph_oe) | (pad_out ^ periph_out)) & func_en) == '0);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_irq_in & ~inen_q) == '0);

  a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr > ADDR_INEN) |=>
      ($stable(data_q) && $stable(dir_q) && $stable(inen_q) && $stable(func_en) && $stable(func_sel)));
endmodule

bind gpio_port_mux gpio_port_mux_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .periph_out(periph_out), .periph_oe(periph_oe), .func_en(func_en),
  .func_sel(func_sel), .pin_irq_in(pin_irq_in), .data_q(data_q),
  .dir_q(dir_q), .inen_q(inen_q)
);

// File: tb/gpio_port_mux_tb_top.sv
module gpio_port_mux_tb_top;
  localparam int PINS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] pad_in = '0, pad_out, pad_oe, periph_out = '0, periph_oe = '0;
  logic [15:0] func_en, pin_irq_in;
  logic [31:0] func_sel;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [15:0] m_fen = '0, m_data = '0, m_dir = '0, m_inen = '0, m_sync = '0;
  logic [31:0] m_mux = '0;

  always #2 clk = ~clk;

  gpio_port_mux dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .periph_out(periph_out),
    .periph_oe(periph_oe), .func_en(func_en), .func_sel(func_sel),
    .pin_irq_in(pin_irq_in)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pinval();
    return (m_inen & m_sync) | (~m_inen & m_data);
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    case (a)
      0: return {16'h0, m_fen};
      1: return m_mux;
      2, 3, 4: return {16'h0, exp_pinval()};
      5, 6, 7: return {16'h0, m_dir};
      8: return {16'h0, m_inen};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input int a);
    case (a)
      0: return "R5 fen readback";
      1: return "R5 mux readback";
      2, 3, 4: return "R9 pin value read";
      5, 6, 7: return "R4 direction read";
      8: return "R5 inen readback";
      default: return "R11 unmapped read";
    endcase
  endfunction

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      0: m_fen = v[15:0];
      1: m_mux = v;
      2: m_data = v[15:0];
      3: m_data = m_data | v[15:0];
      4: m_data = m_data & ~v[15:0];
      5: m_dir = v[15:0];
      6: m_dir = m_dir | v[15:0];
      7: m_dir = m_dir & ~v[15:0];
      8: m_inen = v[15:0];
      default: ;
    endcase
  endtask

  task automatic set_pad(input logic [15:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
    m_sync = v;
  endtask

  task automatic check_all();
    for (int a = 0; a < 16; a++) begin
      reg_addr = 4'(a);
      #0.5;
      check(reg_rdata == exp_read(a), read_tag(a), reg_rdata, exp_read(a));
    end
    check(pad_out == ((m_fen & periph_out) | (~m_fen & m_data)), "R6/R7 pad_out", {16'h0, pad_out},
          {16'h0, (m_fen & periph_out) | (~m_fen & m_data)});
    check(pad_oe == ((m_fen & periph_oe) | (~m_fen & m_dir)), "R6/R7 pad_oe", {16'h0, pad_oe},
          {16'h0, (m_fen & periph_oe) | (~m_fen & m_dir)});
    check(func_en == m_fen, "R7 func_en", {16'h0, func_en}, {16'h0, m_fen});
    check(func_sel == m_mux, "R8 func_sel", func_sel, m_mux);
    check(pin_irq_in == (m_sync & m_inen), "R10 pin_irq_in", {16'h0, pin_irq_in}, {16'h0, m_sync & m_inen});
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_1234));
    pad_in = 16'hA5C3;
    repeat (3) @(negedge clk);
    // R1: reset state, pads low while in reset
    check(pad_oe == 16'h0, "R1 pad_oe in reset", {16'h0, pad_oe}, 32'h0);
    check(pin_irq_in == 16'h0, "R1 irq in reset", {16'h0, pin_irq_in}, 32'h0);
    rst_n = 1'b1;
    m_sync = pad_in;
    repeat (3) @(negedge clk);
    check_all();

    // R2/R3 directed: alias touches only the written bits
    wr(2, 32'h0000_0F0F);
    wr(3, 32'h0000_8001);
    reg_addr = 4'd2; #0.5;
    check(reg_rdata == 32'h0000_8F0F, "R2 data set alias", reg_rdata, 32'h0000_8F0F);
    wr(4, 32'h0000_0101);
    reg_addr = 4'd3; #0.5;
    check(reg_rdata == 32'h0000_8E0E, "R3 data clear alias", reg_rdata, 32'h0000_8E0E);

    // R4 directed
    wr(6, 32'hFFFF_00F0);
    wr(7, 32'h0000_0030);
    reg_addr = 4'd6; #0.5;
    check(reg_rdata == 32'h0000_00C0, "R4 dir set/clear read", reg_rdata, 32'h0000_00C0);

    // R5: upper bits of 16-bit register dropped; mux keeps all 32
    wr(8, 32'hDEAD_0000);
    reg_addr = 4'd8; #0.5;
    check(reg_rdata == 32'h0, "R5 inen upper bits dropped", reg_rdata, 32'h0);
    wr(1, 32'hC0DE_1B2E);
    check(func_sel[3:2] == 2'b11, "R8 pin1 code position", {30'h0, func_sel[3:2]}, 32'h3);

    // R9: synchroniser depth of two edges
    wr(8, 32'h0000_FFFF);
    set_pad(16'h0000);
    @(negedge clk); pad_in = 16'hFFFF;
    @(negedge clk); reg_addr = 4'd2; #0.5;
    check(reg_rdata == 32'h0, "R9 one edge after pad change", reg_rdata, 32'h0);
    check(pin_irq_in == 16'h0, "R10 one edge after pad change", {16'h0, pin_irq_in}, 32'h0);
    @(negedge clk); #0.5;
    check(reg_rdata == 32'h0000_FFFF, "R9 two edges after pad change", reg_rdata, 32'h0000_FFFF);
    m_sync = 16'hFFFF;
    wr(8, 32'h0000_00FF);
    check_all();

    // R11 directed
    wr(12, 32'hFFFF_FFFF);
    check_all();

    // Constrained random
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 7) begin
        int a;
        a = int'($urandom % 16);
        if ($urandom % 4 == 0) a = 3 + int'($urandom % 2) * 3;
        wr(a, $urandom);
      end else if (op < 9) begin
        set_pad(16'($urandom));
      end else begin
        @(negedge clk);
        periph_out = 16'($urandom);
        periph_oe = 16'($urandom);
      end
      check_all();
    end

    // R1 again: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_fen = '0; m_mux = '0; m_data = '0; m_dir = '0; m_inen = '0;
    r = 32'h0;
    check(func_sel == r, "R1 reset clears mux", func_sel, r);
    check_all();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule